// File: doc/BRIEF.md
# Virtual Output Queue Crossbar Scheduler

This block is the queueing and matching core of a small input-queued switch with `N` ingress ports and `N` egress ports (3 by 3 by default). Every ingress port accepts fixed-size packets through a ready/valid handshake. Each packet carries a binary destination index and a payload. In the normal mode, each ingress port stores packets in one queue per egress port. In the alternate mode, each ingress port stores packets in one shared arrival-order FIFO, which makes head-of-line blocking visible.

A time slot is any clock cycle in which `run` is high. In each slot a single-pass request/grant/accept matcher pairs ingress ports with egress ports. Each egress port grants one requester in round-robin order. Each ingress port then accepts one of its grants, also in round-robin order. The matched packets are dequeued and presented on the egress ports in the following cycle. For each slot, one egress port can be declared unavailable. Three counters expose the totals needed to derive average throughput and to measure blocking: packets sent, slots run, and blocking events.

The mode input is expected to change only while all queues are empty. A write to a full queue, or a write with a destination index that is not a port, is refused by holding ready low.

Top module: `voqx_sched`

## Requirements
- R1: A packet is stored when `in_valid` and `in_ready` are both high at a clock edge. The destination field is the binary egress index, 0 to N-1. In queue-per-destination mode (`fifo_mode`=0), the packet goes into that input's queue for that destination.
- R2: `in_ready` is low when the queue the packet would enter already holds DEPTH packets. In queue-per-destination mode, that is the queue for its destination, and other destinations of the same input stay ready. In shared-FIFO mode (`fifo_mode`=1), it is the input's single FIFO.
- R3: A destination index of N or above is refused: `in_ready` is low, and nothing is stored.
- R4: In a slot, each egress port sends at most one packet and each ingress port sends at most one packet. The packet appears on `out_valid`, `out_data` and `out_src` (sending input index) one cycle after the slot. When `run` is low, `out_valid` is all zero in the next cycle.
- R5: When `busy_en` is high with `busy_port` = k, egress port k sends nothing for that slot.
- R6: In queue-per-destination mode, a stalled queue (busy output or a lost grant) does not stop the same input's queues for other outputs from sending in that same slot.
- R7: In shared-FIFO mode, only the head packet of each input can be sent, and an input's packets leave in arrival order.
- R8: `block_count` increases by exactly one for each shared-FIFO slot in which at least one input holds packets but sends none. It never changes in queue-per-destination mode.
- R9: Each egress port serves contending inputs in rotating order. After reset, input 0 has priority. After a grant is accepted, priority moves to one past the accepted input. An unaccepted grant leaves the priority unchanged.
- R10: An input that receives several grants in a slot takes the one at or after its own pointer (output 0 after reset), then moves its pointer one past the taken output. The other outputs stay queued.
- R11: `slot_count` increases by one in each slot. `sent_count` increases by the number of packets sent. Both counters hold while `run` is low.
- R12: After reset, all counters read zero, `out_valid` is zero, and every input is ready for any valid destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run | input | 1 | High marks this cycle as a scheduling slot |
| fifo_mode | input | 1 | 0 = queue per destination, 1 = single shared FIFO per input |
| busy_en | input | 1 | An egress port is unavailable in this slot |
| busy_port | input | PW | Index of the unavailable egress port |
| in_valid | input | N | Per-input packet valid |
| in_ready | output | N | Per-input acceptance |
| in_dest | input | N*PW | Per-input destination index, input i at bits [i*PW +: PW] |
| in_data | input | N*DW | Per-input payload, input i at bits [i*DW +: DW] |
| out_valid | output | N | Per-output packet valid |
| out_data | output | N*DW | Per-output payload |
| out_src | output | N*PW | Per-output index of the sending input |
| sent_count | output | CNT_W | Running total of packets sent |
| slot_count | output | CNT_W | Running total of slots |
| block_count | output | CNT_W | Running total of shared-FIFO blocking slots |

## Verification
The bench loads a packet for a busy output in front of a packet for an idle output at the same input, and runs that pattern in both modes. A design that leaked blocking into the per-destination queues would send nothing, and one that looked past the FIFO head would send the second packet early. Three inputs contend for one output, with one input holding two packets, to check that priority rotates and that the first input is not favoured twice. One input holds packets for two outputs, which an input-side arbiter that accepts both would double-send. Full queues, out-of-range destinations and a head stalled by another input's grant are probed at the handshake and on the blocking counter.

// File: rtl/voqx_pkg.sv
package voqx_pkg;

  typedef enum logic {
    MODE_VOQ  = 1'b0,
    MODE_FIFO = 1'b1
  } qmode_e;

endpackage

// File: rtl/voqx_fifo.sv
module voqx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_q, rd_d, wr_q, wr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_q];

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (do_push) wr_d = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    if (do_pop)  rd_d = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    case ({do_push, do_pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= din;
  end

endmodule

// File: rtl/voqx_rr.sv
module voqx_rr #(
  parameter int N  = 3,
  parameter int PW = 2
) (
  input  logic [N-1:0]  req,
  input  logic [PW-1:0] ptr,
  output logic [N-1:0]  gnt
);

  always_comb begin
    logic found;
    gnt   = '0;
    found = 1'b0;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = (int'(ptr) + k) % N;
      if (!found && req[idx]) begin
        gnt[idx] = 1'b1;
        found    = 1'b1;
      end
    end
  end

endmodule

// File: rtl/voqx_ingress.sv
module voqx_ingress #(
  parameter int N     = 3,
  parameter int PW    = 2,
  parameter int DW    = 8,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_mode,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [PW-1:0] in_dest,
  input  logic [DW-1:0] in_data,
  input  logic [N-1:0]  avail,
  input  logic [N-1:0]  take,
  output logic [N-1:0]  req,
  output logic [DW-1:0] take_data,
  output logic          holds
);

  logic [N-1:0]       voq_full, voq_empty;
  logic [DW-1:0]      voq_dout [N];
  logic               ff_full, ff_empty;
  logic [PW+DW-1:0]   ff_dout;
  logic [PW-1:0]      head_dest;
  logic [DW-1:0]      head_data;
  logic               dest_ok;
  logic               sel_full;

  assign dest_ok   = (int'(in_dest) < N);
  assign head_dest = ff_dout[PW+DW-1:DW];
  assign head_data = ff_dout[DW-1:0];

  for (genvar j = 0; j < N; j++) begin : g_voq
    voqx_fifo #(.W(DW), .DEPTH(DEPTH)) u_q (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (in_valid && dest_ok && !fifo_mode && (in_dest == PW'(j))),
      .din   (in_data),
      .pop   (take[j] && !fifo_mode),
      .dout  (voq_dout[j]),
      .empty (voq_empty[j]),
      .full  (voq_full[j])
    );
  end

  voqx_fifo #(.W(PW + DW), .DEPTH(DEPTH)) u_shared (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (in_valid && dest_ok && fifo_mode),
    .din   ({in_dest, in_data}),
    .pop   (fifo_mode && (|take)),
    .dout  (ff_dout),
    .empty (ff_empty),
    .full  (ff_full)
  );

  always_comb begin
    sel_full = 1'b0;
    for (int j = 0; j < N; j++) begin
      if (in_dest == PW'(j)) sel_full = voq_full[j];
    end
    in_ready = dest_ok && (fifo_mode ? !ff_full : !sel_full);
  end

  always_comb begin
    for (int j = 0; j < N; j++) begin
      if (fifo_mode) req[j] = !ff_empty && (head_dest == PW'(j)) && avail[j];
      else           req[j] = !voq_empty[j] && avail[j];
    end
  end

  always_comb begin
    take_data = '0;
    for (int j = 0; j < N; j++) begin
      if (take[j]) take_data = fifo_mode ? head_data : voq_dout[j];
    end
  end

  assign holds = fifo_mode ? !ff_empty : !(&voq_empty);

endmodule

// File: rtl/voqx_sched.sv
module voqx_sched #(
  parameter int N     = 3,
  parameter int DW    = 8,
  parameter int DEPTH = 4,
  parameter int CNT_W = 16,
  parameter int PW    = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            fifo_mode,
  input  logic            busy_en,
  input  logic [PW-1:0]   busy_port,
  input  logic [N-1:0]    in_valid,
  output logic [N-1:0]    in_ready,
  input  logic [N*PW-1:0] in_dest,
  input  logic [N*DW-1:0] in_data,
  output logic [N-1:0]    out_valid,
  output logic [N*DW-1:0] out_data,
  output logic [N*PW-1:0] out_src,
  output logic [CNT_W-1:0] sent_count,
  output logic [CNT_W-1:0] slot_count,
  output logic [CNT_W-1:0] block_count
);

  import voqx_pkg::*;

  qmode_e        mode;
  logic          mode_fifo;
  logic [1:0]    rsync_q;
  logic          srst_n;

  logic [N-1:0]  busy_vec, avail;
  logic [N-1:0]  req_m   [N];   // [input][output]
  logic [N-1:0]  req_col [N];   // [output][input]
  logic [N-1:0]  gnt_col [N];   // [output][input]
  logic [N-1:0]  gnt_row [N];   // [input][output]
  logic [N-1:0]  acc_m   [N];   // [input][output]
  logic [N-1:0]  take_m  [N];
  logic [DW-1:0] tdata   [N];
  logic [N-1:0]  holds, served;

  logic [PW-1:0] optr_q [N], optr_d [N];
  logic [PW-1:0] iptr_q [N], iptr_d [N];
  logic [N-1:0]  ovld_q, ovld_d;
  logic [DW-1:0] odata_q [N], odata_d [N];
  logic [PW-1:0] osrc_q  [N], osrc_d  [N];
  logic [CNT_W-1:0] sent_q, sent_d, slot_q, slot_d, blk_q, blk_d;
  logic          blocked_slot;

  assign mode      = qmode_e'(fifo_mode);
  assign mode_fifo = (mode == MODE_FIFO);

  // Reset: asserted asynchronously, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign srst_n = rsync_q[1];

  always_comb begin
    for (int o = 0; o < N; o++) busy_vec[o] = busy_en && (busy_port == PW'(o));
    avail = ~busy_vec;
  end

  for (genvar i = 0; i < N; i++) begin : g_in
    assign take_m[i] = run ? acc_m[i] : '0;
    voqx_ingress #(.N(N), .PW(PW), .DW(DW), .DEPTH(DEPTH)) u_ing (
      .clk       (clk),
      .rst_n     (srst_n),
      .fifo_mode (mode_fifo),
      .in_valid  (in_valid[i]),
      .in_ready  (in_ready[i]),
      .in_dest   (in_dest[i*PW +: PW]),
      .in_data   (in_data[i*DW +: DW]),
      .avail     (avail),
      .take      (take_m[i]),
      .req       (req_m[i]),
      .take_data (tdata[i]),
      .holds     (holds[i])
    );
    voqx_rr #(.N(N), .PW(PW)) u_acc (
      .req (gnt_row[i]),
      .ptr (iptr_q[i]),
      .gnt (acc_m[i])
    );
  end

  always_comb begin
    for (int o = 0; o < N; o++)
      for (int i = 0; i < N; i++) req_col[o][i] = req_m[i][o];
  end

  for (genvar o = 0; o < N; o++) begin : g_out
    voqx_rr #(.N(N), .PW(PW)) u_gnt (
      .req (req_col[o]),
      .ptr (optr_q[o]),
      .gnt (gnt_col[o])
    );
  end

  always_comb begin
    for (int i = 0; i < N; i++)
      for (int o = 0; o < N; o++) gnt_row[i][o] = gnt_col[o][i];
  end

  // Next state: pointers, egress registers, counters
  always_comb begin
    int sent_inc;
    sent_inc = 0;
    for (int o = 0; o < N; o++) begin
      optr_d[o]  = optr_q[o];
      ovld_d[o]  = 1'b0;
      odata_d[o] = '0;
      osrc_d[o]  = '0;
    end
    for (int i = 0; i < N; i++) begin
      iptr_d[i] = iptr_q[i];
      served[i] = |acc_m[i];
    end
    for (int i = 0; i < N; i++) begin
      for (int o = 0; o < N; o++) begin
        if (run && acc_m[i][o]) begin
          optr_d[o]  = PW'((i + 1) % N);
          iptr_d[i]  = PW'((o + 1) % N);
          ovld_d[o]  = 1'b1;
          odata_d[o] = tdata[i];
          osrc_d[o]  = PW'(i);
          sent_inc   = sent_inc + 1;
        end
      end
    end
    blocked_slot = mode_fifo && |(holds & ~served);
    sent_d = sent_q + CNT_W'(sent_inc);
    slot_d = slot_q + 1'b1;
    blk_d  = blocked_slot ? blk_q + 1'b1 : blk_q;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      for (int k = 0; k < N; k++) begin
        optr_q[k]  <= '0;
        iptr_q[k]  <= '0;
        odata_q[k] <= '0;
        osrc_q[k]  <= '0;
      end
      ovld_q <= '0;
      sent_q <= '0;
      slot_q <= '0;
      blk_q  <= '0;
    end else begin
      ovld_q <= ovld_d;
      if (run) begin
        for (int k = 0; k < N; k++) begin
          optr_q[k]  <= optr_d[k];
          iptr_q[k]  <= iptr_d[k];
          odata_q[k] <= odata_d[k];
          osrc_q[k]  <= osrc_d[k];
        end
        sent_q <= sent_d;
        slot_q <= slot_d;
        blk_q  <= blk_d;
      end
    end
  end

  always_comb begin
    for (int o = 0; o < N; o++) begin
      out_data[o*DW +: DW] = odata_q[o];
      out_src[o*PW +: PW]  = osrc_q[o];
    end
  end

  assign out_valid   = ovld_q;
  assign sent_count  = sent_q;
  assign slot_count  = slot_q;
  assign block_count = blk_q;

endmodule

// File: rtl/voqx_sched_chk.sv
module voqx_sched_chk #(
  parameter int N     = 3,
  parameter int PW    = 2,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             fifo_mode,
  input logic             busy_en,
  input logic [PW-1:0]    busy_port,
  input logic [N*PW-1:0]  in_dest,
  input logic [N-1:0]     in_ready,
  input logic [N-1:0]     out_valid,
  input logic [N*PW-1:0]  out_src,
  input logic [CNT_W-1:0] sent_count,
  input logic [CNT_W-1:0] slot_count,
  input logic [CNT_W-1:0] block_count
);

  for (genvar k = 0; k < N; k++) begin : g_k
    // R5: a busy output stays silent after that slot
    p_busy_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (run && busy_en && busy_port == PW'(k)) |=> !out_valid[k]);
    // R3: out-of-range destinations are refused
    p_bad_dest_refused_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(in_dest[k*PW +: PW]) >= N) |-> !in_ready[k]);
  end

  // R4: egress valid only after a slot
  p_valid_needs_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|out_valid) |-> $past(run));

  // R11: slot counter steps once per slot
  p_slot_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> (slot_count == $past(slot_count) + CNT_W'(1)));

  // R11: sent counter tracks the packets presented at egress
  p_sent_tracks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (sent_count == $past(sent_count) + CNT_W'($countones(out_valid))));

  // R11: counters hold while idle
  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ($stable(slot_count) && $stable(sent_count) && $stable(block_count)));

  // R8: no blocking events in queue-per-destination mode
  p_voq_no_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_mode |=> $stable(block_count));

  // R4: no input appears on two outputs in the same cycle
  always @(posedge clk) begin
    if (rst_n) begin
      for (int a = 0; a < N; a++)
        for (int b = a + 1; b < N; b++)
          a_one_per_input_r4: assert (!(out_valid[a] && out_valid[b] &&
            out_src[a*PW +: PW] == out_src[b*PW +: PW]));
    end
  end

endmodule

bind voqx_sched voqx_sched_chk #(.N(N), .PW(PW), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (srst_n),
  .run         (run),
  .fifo_mode   (fifo_mode),
  .busy_en     (busy_en),
  .busy_port   (busy_port),
  .in_dest     (in_dest),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_src     (out_src),
  .sent_count  (sent_count),
  .slot_count  (slot_count),
  .block_count (block_count)
);

// File: tb/voqx_sched_tb.sv
module voqx_sched_tb;

  localparam int N = 3, DW = 8, PW = 2, DEPTH = 4, CW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          run, fifo_mode, busy_en;
  logic [PW-1:0] busy_port;
  logic [N-1:0]  in_valid, in_ready, out_valid;
  logic [N*PW-1:0] in_dest, out_src;
  logic [N*DW-1:0] in_data, out_data;
  logic [CW-1:0] sent_count, slot_count, block_count;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  voqx_sched #(.N(N), .DW(DW), .DEPTH(DEPTH), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .run(run), .fifo_mode(fifo_mode),
    .busy_en(busy_en), .busy_port(busy_port),
    .in_valid(in_valid), .in_ready(in_ready), .in_dest(in_dest), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data), .out_src(out_src),
    .sent_count(sent_count), .slot_count(slot_count), .block_count(block_count)
  );

  function automatic int od(int o); return int'(out_data[o*DW +: DW]); endfunction
  function automatic int os(int o); return int'(out_src[o*PW +: PW]); endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(bit fm);
    rst_n = 1'b0; run = 0; busy_en = 0; busy_port = '0; fifo_mode = fm;
    in_valid = '0; in_dest = '0; in_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // drive one packet; exp_rdy states whether the handshake must accept it
  task automatic push(int i, int d, int v, bit exp_rdy, string tag);
    @(negedge clk);
    in_valid[i] = 1'b1;
    in_dest[i*PW +: PW] = PW'(d);
    in_data[i*DW +: DW] = DW'(v);
    #1 check(tag, int'(in_ready[i]), int'(exp_rdy));
    @(posedge clk);
    #1 in_valid[i] = 1'b0;
  endtask

  task automatic slot(bit be, int bp);
    @(negedge clk);
    run = 1'b1; busy_en = be; busy_port = PW'(bp);
    @(posedge clk);
    #1 run = 1'b0; busy_en = 1'b0;
  endtask

  task automatic t_reset;
    do_reset(0);
    check("R12 out_valid", int'(out_valid), 0);
    check("R12 sent_count", int'(sent_count), 0);
    check("R12 slot_count", int'(slot_count), 0);
    check("R12 block_count", int'(block_count), 0);
    check("R12 in_ready", int'(in_ready), 7);
  endtask

  task automatic t_voq_bypass;
    do_reset(0);
    push(0, 0, 8'hA0, 1, "R1 push d0");
    push(0, 1, 8'hA1, 1, "R1 push d1");
    slot(1, 0);
    check("R6 R5 valid with out0 busy", int'(out_valid), 3'b010);
    check("R6 data out1", od(1), 8'hA1);
    check("R4 src out1", os(1), 0);
    slot(0, 0);
    check("R1 valid out0", int'(out_valid), 3'b001);
    check("R1 data out0", od(0), 8'hA0);
    repeat (3) @(negedge clk);
    check("R4 idle valid", int'(out_valid), 0);
    check("R11 sent", int'(sent_count), 2);
    check("R11 slots", int'(slot_count), 2);
    check("R8 no block in voq mode", int'(block_count), 0);
  endtask

  task automatic t_fifo_hol;
    do_reset(1);
    push(0, 0, 8'hB0, 1, "R1 fifo push");
    push(0, 1, 8'hB1, 1, "R1 fifo push");
    slot(1, 0);
    check("R7 R5 head blocked", int'(out_valid), 0);
    check("R8 block event", int'(block_count), 1);
    slot(0, 0);
    check("R7 head first", int'(out_valid), 3'b001);
    check("R7 head data", od(0), 8'hB0);
    slot(0, 0);
    check("R7 second next", int'(out_valid), 3'b010);
    check("R7 second data", od(1), 8'hB1);
    check("R8 no further events", int'(block_count), 1);
    check("R11 slots fifo", int'(slot_count), 3);
  endtask

  task automatic t_fifo_contend;
    do_reset(1);
    push(0, 2, 8'hE0, 1, "R1 push");
    push(1, 2, 8'hE1, 1, "R1 push");
    push(1, 0, 8'hE2, 1, "R1 push");
    slot(0, 0);
    check("R7 lost grant blocks idle out0", int'(out_valid), 3'b100);
    check("R9 first src", os(2), 0);
    check("R8 granted-elsewhere event", int'(block_count), 1);
    slot(0, 0);
    check("R9 rotated src", os(2), 1);
    check("R7 E1 data", od(2), 8'hE1);
    slot(0, 0);
    check("R7 behind packet", int'(out_valid), 3'b001);
    check("R7 E2 data", od(0), 8'hE2);
    check("R8 count stays", int'(block_count), 1);
  endtask

  task automatic t_rr_output;
    int exp_src [4] = '{0, 1, 2, 0};
    int exp_dat [4] = '{8'hC0, 8'hC2, 8'hC3, 8'hC1};
    do_reset(0);
    push(0, 2, 8'hC0, 1, "R1 push");
    push(0, 2, 8'hC1, 1, "R1 push");
    push(1, 2, 8'hC2, 1, "R1 push");
    push(2, 2, 8'hC3, 1, "R1 push");
    for (int s = 0; s < 4; s++) begin
      slot(0, 0);
      check("R9 single winner", int'(out_valid), 3'b100);
      check("R9 rotation src", os(2), exp_src[s]);
      check("R9 rotation data", od(2), exp_dat[s]);
    end
    check("R11 sent rr", int'(sent_count), 4);
  endtask

  task automatic t_rr_input;
    do_reset(0);
    push(0, 1, 8'hD1, 1, "R1 push");
    push(0, 0, 8'hD0, 1, "R1 push");
    slot(0, 0);
    check("R10 accept lowest at pointer", int'(out_valid), 3'b001);
    check("R10 data", od(0), 8'hD0);
    slot(0, 0);
    check("R10 other waits", int'(out_valid), 3'b010);
    check("R10 data2", od(1), 8'hD1);
  endtask

  task automatic t_match;
    do_reset(0);
    for (int i = 0; i < N; i++) push(i, i, 16 * i + 5, 1, "R1 push");
    slot(0, 0);
    check("R4 full matching", int'(out_valid), 3'b111);
    for (int o = 0; o < N; o++) check("R4 match src", os(o), o);
    check("R11 sent three", int'(sent_count), 3);
  endtask

  task automatic t_full;
    do_reset(0);
    for (int k = 0; k < DEPTH; k++) push(0, 1, k, 1, "R2 fill voq");
    push(0, 1, 8'h77, 0, "R2 full voq refused");
    push(0, 0, 8'h55, 1, "R2 other voq ready");
    do_reset(1);
    for (int k = 0; k < DEPTH; k++) push(2, k % 3, k, 1, "R2 fill fifo");
    push(2, 1, 8'h66, 0, "R2 full fifo refused");
    push(1, 1, 8'h44, 1, "R2 other input ready");
    slot(0, 0);
    check("R2 after fill", int'(out_valid), 3'b011);
    check("R2 out1 from input1", os(1), 1);
    check("R2 out0 head of input2", od(0), 0);
  endtask

  task automatic t_bad_dest;
    do_reset(0);
    push(1, 3, 8'h99, 0, "R3 bad dest refused");
    slot(0, 0);
    check("R3 nothing stored", int'(out_valid), 0);
    check("R3 nothing sent", int'(sent_count), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_voq_bypass();
    t_fifo_hol();
    t_fifo_contend();
    t_rr_output();
    t_rr_input();
    t_match();
    t_full();
    t_bad_dest();
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule